// File: doc/BRIEF.md
# Status Register Write-Protection Unit

This block keeps the protection state of a serial EEPROM engine and takes every decision on whether a write may go ahead. The command decoder in front of it sends one-cycle strobes for write-enable, write-disable, status write (with its data byte) and memory write (with its target address). The block answers each write-type strobe with a one-cycle grant or deny pulse on the cycle after the strobe. While a granted write cycle runs, it reports write-in-progress until the write timer pulses the end of the cycle. The status byte it presents is live on every cycle, so a status read can stream it repeatedly and each byte shows the current write-in-progress flag.

Protection works on two levels. Two block-protect bits lock a fixed upper part of the array: a quarter, a half, or all of it. A status write-disable bit, together with an active-low external write-protect pin, locks the status register itself against change.

A three-state machine tracks the activity. ST_IDLE accepts commands. ST_ARRAY runs a granted memory write. ST_STATUS runs a granted status write. The transitions are T_WR_GO (ST_IDLE to ST_ARRAY on a granted memory write), T_SR_GO (ST_IDLE to ST_STATUS on a granted status write), and T_DONE (ST_ARRAY or ST_STATUS back to ST_IDLE on the end-of-cycle pulse).

Top module: `wp_status_unit`

## Requirements
- R1: The status byte has these fields: bit 7 is the status write-disable bit (SRWD), bit 3 is BP1, bit 2 is BP0, bit 1 is the write enable latch (WEL), and bit 0 is write-in-progress (WIP). Bits 6 to 4 always read 0.
- R2: After reset the status byte is 00h, and neither grant nor deny is asserted.
- R3: A write-enable strobe in ST_IDLE sets WEL from the next cycle on. A write-disable strobe in ST_IDLE clears it.
- R4: A memory write or status write requested while WEL is 0 is answered by a deny pulse on the next cycle. No write cycle starts.
- R5: The {BP1,BP0} code selects the protected addresses of a 16-bit address. 00 protects none. 01 protects the addresses whose two top bits are 11. 10 protects the addresses whose top bit is 1. 11 protects all addresses. A memory write to a protected address is denied.
- R6: A status write is granted when WEL is 1 and the register is not hardware locked. It loads data bits 7, 3 and 2 into SRWD, BP1 and BP0. All other data bits are discarded.
- R7: When SRWD is 1 and the write-protect pin is low, every status write is denied and the status byte is unchanged. With the pin high, the status write is accepted.
- R8: Grant and deny are single-cycle pulses, one cycle after the request, and never both at once. WIP reads 1 from the grant cycle until the cycle after the end-of-cycle pulse.
- R9: WEL is cleared when a write cycle ends and when a request is denied.
- R10: While a cycle runs, write and status-write requests are denied, and write-enable and write-disable strobes have no effect. An end-of-cycle pulse in ST_IDLE has no effect.
- R11: If several strobes arrive in one cycle, the priority is: memory write, then status write, then write-disable, then write-enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wren_i | input | 1 | Write-enable command strobe |
| wrdi_i | input | 1 | Write-disable command strobe |
| wrsr_i | input | 1 | Status-write command strobe |
| wrsr_data_i | input | 8 | Data byte of the status write |
| wr_req_i | input | 1 | Memory write request strobe |
| wr_addr_i | input | ADDR_W | Target address of the memory write |
| wp_n_i | input | 1 | External write-protect pin, low = protect |
| cycle_done_i | input | 1 | End-of-write-cycle pulse from the timer |
| status_o | output | 8 | Live status byte |
| wr_grant_o | output | 1 | Request granted, write cycle starts |
| wr_deny_o | output | 1 | Request refused |

## Verification
Some properties are checked by the assertions on every cycle:
- the zero bits of the status byte;
- grant and deny never both high;
- no grant without WEL, and no grant for a write while BP is 11;
- the hardware lock refusing status writes and leaving the status byte untouched;
- WIP holding until the end-of-cycle pulse;
- WIP and WEL both dropping right after that pulse.

Other behaviour shows only through the bench's scenarios, which compare the outputs against a model. That covers the exact address boundaries of the quarter and half ranges, the masking of the status-write data byte, the strobe priority, and the strobes that are ignored during a cycle.

// File: rtl/wpu_pkg.sv
package wpu_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ARRAY  = 2'd1,
        ST_STATUS = 2'd2
    } wpu_state_e;

    localparam int SR_SRWD = 7;
    localparam int SR_BP1  = 3;
    localparam int SR_BP0  = 2;
    localparam int SR_WEL  = 1;
    localparam int SR_WIP  = 0;
endpackage

// File: rtl/wpu_range_check.sv
module wpu_range_check #(
    parameter int ADDR_W = 16
) (
    input  logic [1:0]        bp,
    input  logic [ADDR_W-1:0] addr,
    output logic              locked
);
    localparam int TOP = ADDR_W - 1;

    logic unused_low;
    assign unused_low = ^addr[ADDR_W-3:0];

    always_comb begin
        unique case (bp)
            2'b00:   locked = 1'b0;
            2'b01:   locked = addr[TOP] & addr[TOP-1];
            2'b10:   locked = addr[TOP];
            default: locked = 1'b1;
        endcase
    end
endmodule

// File: rtl/wpu_status_regs.sv
module wpu_status_regs (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set_wel,
    input  logic       clr_wel,
    input  logic       load_sr,
    input  logic [7:0] sr_data,
    output logic       srwd,
    output logic [1:0] bp,
    output logic       wel
);
    import wpu_pkg::*;

    logic unused_data;
    assign unused_data = ^{sr_data[6:4], sr_data[1:0]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            srwd <= 1'b0;
            bp   <= 2'b00;
        end else if (load_sr) begin
            srwd <= sr_data[SR_SRWD];
            bp   <= {sr_data[SR_BP1], sr_data[SR_BP0]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       wel <= 1'b0;
        else if (clr_wel) wel <= 1'b0;
        else if (set_wel) wel <= 1'b1;
    end
endmodule

// File: rtl/wp_status_unit.sv
module wp_status_unit #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wren_i,
    input  logic              wrdi_i,
    input  logic              wrsr_i,
    input  logic [7:0]        wrsr_data_i,
    input  logic              wr_req_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic              wp_n_i,
    input  logic              cycle_done_i,
    output logic [7:0]        status_o,
    output logic              wr_grant_o,
    output logic              wr_deny_o
);
    import wpu_pkg::*;

    wpu_state_e state_q, state_d;
    logic       srwd, wel, addr_locked, sr_locked;
    logic [1:0] bp;
    logic       set_wel, clr_wel, load_sr, grant_d, deny_d;

    wpu_range_check #(.ADDR_W(ADDR_W)) u_range (
        .bp     (bp),
        .addr   (wr_addr_i),
        .locked (addr_locked)
    );

    wpu_status_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_wel (set_wel),
        .clr_wel (clr_wel),
        .load_sr (load_sr),
        .sr_data (wrsr_data_i),
        .srwd    (srwd),
        .bp      (bp),
        .wel     (wel)
    );

    assign sr_locked = srwd & ~wp_n_i;

    // Decisions and next state
    always_comb begin
        state_d = state_q;
        set_wel = 1'b0;
        clr_wel = 1'b0;
        load_sr = 1'b0;
        grant_d = 1'b0;
        deny_d  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (wr_req_i) begin
                    if (wel && !addr_locked) begin
                        grant_d = 1'b1;
                        state_d = ST_ARRAY;      // T_WR_GO
                    end else begin
                        deny_d  = 1'b1;
                        clr_wel = 1'b1;
                    end
                end else if (wrsr_i) begin
                    if (wel && !sr_locked) begin
                        grant_d = 1'b1;
                        load_sr = 1'b1;
                        state_d = ST_STATUS;     // T_SR_GO
                    end else begin
                        deny_d  = 1'b1;
                        clr_wel = 1'b1;
                    end
                end else if (wrdi_i) begin
                    clr_wel = 1'b1;
                end else if (wren_i) begin
                    set_wel = 1'b1;
                end
            end
            ST_ARRAY, ST_STATUS: begin
                if (wr_req_i || wrsr_i) begin
                    deny_d  = 1'b1;
                    clr_wel = 1'b1;
                end
                if (cycle_done_i) begin
                    clr_wel = 1'b1;
                    state_d = ST_IDLE;           // T_DONE
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_grant_o <= 1'b0;
            wr_deny_o  <= 1'b0;
        end else begin
            wr_grant_o <= grant_d;
            wr_deny_o  <= deny_d;
        end
    end

    assign status_o = {srwd, 3'b000, bp, wel, (state_q != ST_IDLE)};
endmodule

// File: rtl/wpu_checker.sv
module wpu_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_req_i,
    input logic       wrsr_i,
    input logic       wp_n_i,
    input logic       cycle_done_i,
    input logic [7:0] status_o,
    input logic       wr_grant_o,
    input logic       wr_deny_o
);
    p_zero_bits_r1: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[6:4] == 3'b000);

    p_need_wel_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req_i || wrsr_i) && !status_o[1] |=> !wr_grant_o);

    p_all_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req_i && (status_o[3:2] == 2'b11) |=> !wr_grant_o);

    p_hw_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wrsr_i && !wr_req_i && status_o[7] && !wp_n_i
        |=> wr_deny_o && $stable(status_o[7:2]));

    p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_grant_o && wr_deny_o));

    p_grant_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_grant_o |-> status_o[0]);

    p_wip_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[0] && !cycle_done_i |=> status_o[0]);

    p_end_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[0] && cycle_done_i |=> !status_o[0] && !status_o[1]);
endmodule

bind wp_status_unit wpu_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_req_i     (wr_req_i),
    .wrsr_i       (wrsr_i),
    .wp_n_i       (wp_n_i),
    .cycle_done_i (cycle_done_i),
    .status_o     (status_o),
    .wr_grant_o   (wr_grant_o),
    .wr_deny_o    (wr_deny_o)
);

// File: tb/sim_wp_status_unit.sv
module sim_wp_status_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wren_i = 1'b0, wrdi_i = 1'b0, wrsr_i = 1'b0, wr_req_i = 1'b0;
    logic [7:0]  wrsr_data_i = 8'h00;
    logic [15:0] wr_addr_i = 16'h0000;
    logic        wp_n_i = 1'b1, cycle_done_i = 1'b0;
    logic [7:0]  status_o;
    logic        wr_grant_o, wr_deny_o;

    int checks = 0, errors = 0;
    bit finished = 1'b0;

    bit       m_srwd = 0, m_wel = 0, m_busy = 0;
    bit [1:0] m_bp = 0;

    always #5 clk = ~clk;

    wp_status_unit #(.ADDR_W(16)) u0 (
        .clk(clk), .rst_n(rst_n), .wren_i(wren_i), .wrdi_i(wrdi_i),
        .wrsr_i(wrsr_i), .wrsr_data_i(wrsr_data_i), .wr_req_i(wr_req_i),
        .wr_addr_i(wr_addr_i), .wp_n_i(wp_n_i), .cycle_done_i(cycle_done_i),
        .status_o(status_o), .wr_grant_o(wr_grant_o), .wr_deny_o(wr_deny_o)
    );

    function automatic bit prot(input bit [1:0] bp, input bit [15:0] a);
        case (bp)
            2'b00:   return 1'b0;
            2'b01:   return a[15:14] == 2'b11;
            2'b10:   return a[15];
            default: return 1'b1;
        endcase
    endfunction

    function automatic bit [7:0] exp_status();
        return {m_srwd, 3'b000, m_bp, m_wel, m_busy};
    endfunction

    task automatic step(input string tag, input bit req, input bit sr, input bit di,
                        input bit en, input bit done, input bit [15:0] a,
                        input bit [7:0] d, input bit wp);
        bit g, dn;
        bit [7:0] es;
        @(negedge clk);
        wr_req_i = req; wrsr_i = sr; wrdi_i = di; wren_i = en;
        cycle_done_i = done; wr_addr_i = a; wrsr_data_i = d; wp_n_i = wp;
        g = 0; dn = 0;
        if (m_busy) begin
            if (req || sr) begin dn = 1; m_wel = 0; end
            if (done) begin m_busy = 0; m_wel = 0; end
        end else if (req) begin
            if (m_wel && !prot(m_bp, a)) begin g = 1; m_busy = 1; end
            else begin dn = 1; m_wel = 0; end
        end else if (sr) begin
            if (m_wel && !(m_srwd && !wp)) begin
                g = 1; m_busy = 1; m_srwd = d[7]; m_bp = d[3:2];
            end else begin dn = 1; m_wel = 0; end
        end else if (di) m_wel = 0;
        else if (en) m_wel = 1;
        es = exp_status();
        @(posedge clk);
        #3;
        checks++;
        if (status_o !== es || wr_grant_o !== g || wr_deny_o !== dn) begin
            errors++;
            $display("FAIL %s: status=%02h grant=%0b deny=%0b expected status=%02h grant=%0b deny=%0b",
                     tag, status_o, wr_grant_o, wr_deny_o, es, g, dn);
        end
    endtask

    task automatic idle(input string tag);
        step(tag, 0, 0, 0, 0, 0, 16'h0, 8'h0, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (status_o !== 8'h00 || wr_grant_o !== 1'b0 || wr_deny_o !== 1'b0) begin
            errors++;
            $display("FAIL R2: status=%02h grant=%0b deny=%0b expected 00 0 0",
                     status_o, wr_grant_o, wr_deny_o);
        end
        // R3 latch set and clear
        step("R3", 0, 0, 0, 1, 0, 16'h0, 8'h0, 1);
        step("R3", 0, 0, 1, 0, 0, 16'h0, 8'h0, 1);
        // R4 write without latch
        step("R4", 1, 0, 0, 0, 0, 16'h1234, 8'h0, 1);
        step("R4", 0, 1, 0, 0, 0, 16'h0, 8'h0C, 1);
        // R8 granted array write, WIP holds
        step("R3", 0, 0, 0, 1, 0, 16'h0, 8'h0, 1);
        step("R8", 1, 0, 0, 0, 0, 16'h1234, 8'h0, 1);
        idle("R8");
        // R10 strobes during cycle
        step("R10", 0, 0, 1, 0, 0, 16'h0, 8'h0, 1);
        step("R10", 1, 0, 0, 0, 0, 16'h0010, 8'h0, 1);
        step("R9", 0, 0, 0, 0, 1, 16'h0, 8'h0, 1);
        step("R10", 0, 0, 0, 0, 1, 16'h0, 8'h0, 1);
        // R6 status write with masking
        step("R3", 0, 0, 0, 1, 0, 16'h0, 8'h0, 1);
        step("R6", 0, 1, 0, 0, 0, 16'h0, 8'hFF, 1);
        step("R9", 0, 0, 0, 0, 1, 16'h0, 8'h0, 1);
        // R5 all locked
        step("R3", 0, 0, 0, 1, 0, 16'h0, 8'h0, 1);
        step("R5", 1, 0, 0, 0, 0, 16'h0000, 8'h0, 1);
        // R7 hardware lock, then pin high
        step("R3", 0, 0, 0, 1, 0, 16'h0, 8'h0, 0);
        step("R7", 0, 1, 0, 0, 0, 16'h0, 8'h00, 0);
        step("R3", 0, 0, 0, 1, 0, 16'h0, 8'h0, 0);
        step("R7", 0, 1, 0, 0, 0, 16'h0, 8'h04, 1);
        step("R9", 0, 0, 0, 0, 1, 16'h0, 8'h0, 1);
        // R5 upper quarter boundary
        step("R3", 0, 0, 0, 1, 0, 16'h0, 8'h0, 1);
        step("R5", 1, 0, 0, 0, 0, 16'hBFFF, 8'h0, 1);
        step("R9", 0, 0, 0, 0, 1, 16'h0, 8'h0, 1);
        step("R3", 0, 0, 0, 1, 0, 16'h0, 8'h0, 1);
        step("R5", 1, 0, 0, 0, 0, 16'hC000, 8'h0, 1);
        // R5 upper half boundary, status write allowed with pin low as SRWD=0
        step("R3", 0, 0, 0, 1, 0, 16'h0, 8'h0, 0);
        step("R6", 0, 1, 0, 0, 0, 16'h0, 8'h08, 0);
        step("R9", 0, 0, 0, 0, 1, 16'h0, 8'h0, 1);
        step("R3", 0, 0, 0, 1, 0, 16'h0, 8'h0, 1);
        step("R5", 1, 0, 0, 0, 0, 16'h7FFF, 8'h0, 1);
        step("R9", 0, 0, 0, 0, 1, 16'h0, 8'h0, 1);
        step("R3", 0, 0, 0, 1, 0, 16'h0, 8'h0, 1);
        step("R5", 1, 0, 0, 0, 0, 16'h8000, 8'h0, 1);
        // R11 priority
        step("R11", 0, 0, 1, 1, 0, 16'h0, 8'h0, 1);
        step("R3", 0, 0, 0, 1, 0, 16'h0, 8'h0, 1);
        step("R11", 1, 1, 0, 0, 0, 16'h0100, 8'h0C, 1);
        step("R9", 0, 0, 0, 0, 1, 16'h0, 8'h0, 1);
        step("R3", 0, 0, 0, 1, 0, 16'h0, 8'h0, 1);
        step("R11", 0, 1, 1, 1, 0, 16'h0, 8'h00, 1);
        step("R9", 0, 0, 0, 0, 1, 16'h0, 8'h0, 1);
        // Random traffic
        for (int i = 0; i < 3000; i++) begin
            int r;
            bit done;
            r = $urandom % 10;
            done = m_busy && ($urandom % 3 == 0);
            step("R1", r == 4 || r == 5, r == 6, r == 3, r <= 2, done,
                 16'($urandom), 8'($urandom), 1'($urandom));
        end
        idle("R1");
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule